// File: doc/BRIEF.md
# Dual Halfword Multiply-Accumulate Long Unit

This execution unit performs a signed dual 16-bit multiply and folds the result into a 64-bit accumulator. The accumulator is carried in two 32-bit registers. The surrounding pipeline hands it four things. The first is a 32-bit instruction word. The second is the current contents of the two multiplicand registers and the two accumulator halves. The third is a flag that says whether the instruction's condition held. The fourth is an input strobe. The unit decodes the destination indices, the lane-swap control and the add/subtract control straight from the instruction word.

Each operand is split into a low and a high signed halfword. Each pair of lanes is multiplied. The two products are then summed or differenced at full width, so the result never wraps at 32 bits. That value is added to the 64-bit accumulator modulo 2^64. The new low and high words come back one cycle later. They arrive together with their destination indices and a write enable. The pipeline uses them to update its register file.

The register file, instruction fetch, condition evaluation and flag updates all live outside the unit.

Top module: `dmac_long_unit`

## Requirements
- R1: While reset (synchronous, active high) is applied, and in the first cycle after it is released with no input, `out_valid` and `out_wen` are 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1, and 0 otherwise.
- R3: `out_lo_idx` carries instruction bits 15:12 and `out_hi_idx` carries instruction bits 19:16 of the accepted word.
- R4: When instruction bit 5 is 1, the upper and lower 16-bit halves of the second multiplicand (`rm_val`) are exchanged before multiplying. When bit 5 is 0, `rm_val` is used as is.
- R5: Instruction bit 6 selects the combine operation. A value of 0 gives low-lane product plus high-lane product. A value of 1 gives low-lane product minus high-lane product. Low lane means bits 15:0 and high lane means bits 31:16, each read as signed.
- R6: The combined product value is formed without wrapping at 32 bits. For example, 0x80008000 times 0x80008000 in add mode contributes +2^31 to the accumulator.
- R7: The result is {`acc_hi`,`acc_lo`} plus the sign-extended combined value, modulo 2^64. Bits 31:0 appear on `out_lo` and bits 63:32 on `out_hi`, and carries propagate across the word boundary.
- R8: When instruction bits 31:28 equal 0xE, `out_wen` is 1 regardless of `cond_ok`. For any other code, `out_wen` equals `cond_ok`.
- R9: When `out_wen` is 0 for an accepted word, `out_lo` and `out_hi` return the unchanged `acc_lo` and `acc_hi` inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and instruction present this cycle |
| instr | input | 32 | Instruction word |
| rn_val | input | 32 | First multiplicand register value |
| rm_val | input | 32 | Second multiplicand register value |
| acc_lo | input | 32 | Accumulator low word |
| acc_hi | input | 32 | Accumulator high word |
| cond_ok | input | 1 | Condition evaluated true by the pipeline |
| out_valid | output | 1 | Result present |
| out_lo | output | 32 | New accumulator low word |
| out_hi | output | 32 | New accumulator high word |
| out_lo_idx | output | 4 | Destination index for the low word |
| out_hi_idx | output | 4 | Destination index for the high word |
| out_wen | output | 1 | Write the two destinations |

## Verification
Random operands with random swap, mode and condition settings are compared against a 64-bit reference that the bench computes with its own integer arithmetic. This separates lane pairing errors from sign-handling errors.

Several directed patterns each target one way the design can go wrong:

- Halfwords of 0xFFFF expose unsigned multiplication.
- 0x8000 in both lanes exposes a combine that wraps at 32 bits.
- Asymmetric lane values under both swap settings expose a missing or inverted exchange.
- Subtract mode with unequal products exposes swapped operand order.

A low word near 0xFFFFFFFF checks carry into the high word. A failed condition under a non-always code checks that the write enable drops and the accumulator passes through unchanged.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int INSTR_W  = 32;
  localparam int IDX_W    = 4;
  localparam int COND_W   = 4;
  localparam int COND_LSB = 28;
  localparam int HI_LSB   = 16;
  localparam int LO_LSB   = 12;
  localparam int SWAP_BIT = 5;
  localparam int SUB_BIT  = 6;
  localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;

  typedef struct packed {
    logic [COND_W-1:0] cond;
    logic [IDX_W-1:0]  hi_idx;
    logic [IDX_W-1:0]  lo_idx;
    logic              swap;
    logic              sub;
  } dmac_ctrl_t;
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
  import dmac_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic               cond_ok,
  output dmac_ctrl_t         ctrl,
  output logic               will_write
);
  logic unused_fields;

  always_comb begin
    ctrl.cond   = instr[COND_LSB +: COND_W];
    ctrl.hi_idx = instr[HI_LSB +: IDX_W];
    ctrl.lo_idx = instr[LO_LSB +: IDX_W];
    ctrl.swap   = instr[SWAP_BIT];
    ctrl.sub    = instr[SUB_BIT];
  end

  // Always-code overrides the pipeline's condition result.
  assign will_write = (ctrl.cond == COND_ALWAYS) | cond_ok;

  // Multiplicand indices and opcode bits are resolved by the pipeline.
  assign unused_fields = ^{instr[27:20], instr[11:7], instr[4:0]};
endmodule

// File: rtl/dmac_lanes.sv
module dmac_lanes #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int PROD_W = 2 * HALF_W,
  localparam int COMB_W = PROD_W + 1
) (
  input  logic [WORD_W-1:0]        rn,
  input  logic [WORD_W-1:0]        rm,
  input  logic                     swap,
  input  logic                     sub,
  output logic signed [PROD_W-1:0] prod_lo,
  output logic signed [PROD_W-1:0] prod_hi,
  output logic signed [COMB_W-1:0] comb
);
  logic [WORD_W-1:0] rm_eff;

  function automatic logic [WORD_W-1:0] exchange(input logic [WORD_W-1:0] w);
    return {w[HALF_W-1:0], w[WORD_W-1:HALF_W]};
  endfunction

  function automatic logic signed [PROD_W-1:0] lane_mul(
    input logic [HALF_W-1:0] a, input logic [HALF_W-1:0] b);
    logic signed [PROD_W-1:0] sa, sb;
    sa = PROD_W'($signed(a));
    sb = PROD_W'($signed(b));
    return sa * sb;
  endfunction

  // One extra bit keeps (-2^15)^2 + (-2^15)^2 = 2^31 positive.
  function automatic logic signed [COMB_W-1:0] merge(
    input logic signed [PROD_W-1:0] a, input logic signed [PROD_W-1:0] b,
    input logic do_sub);
    logic signed [COMB_W-1:0] wa, wb;
    wa = {a[PROD_W-1], a};
    wb = {b[PROD_W-1], b};
    return do_sub ? (wa - wb) : (wa + wb);
  endfunction

  assign rm_eff  = swap ? exchange(rm) : rm;
  assign prod_lo = lane_mul(rn[HALF_W-1:0], rm_eff[HALF_W-1:0]);
  assign prod_hi = lane_mul(rn[WORD_W-1:HALF_W], rm_eff[WORD_W-1:HALF_W]);
  assign comb    = merge(prod_lo, prod_hi, sub);
endmodule

// File: rtl/dmac_accum.sv
module dmac_accum #(
  parameter int DATA_W = 32,
  parameter int COMB_W = 33,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic signed [COMB_W-1:0] comb,
  input  logic [DATA_W-1:0]        lo_in,
  input  logic [DATA_W-1:0]        hi_in,
  output logic [DATA_W-1:0]        lo_out,
  output logic [DATA_W-1:0]        hi_out
);
  logic [ACC_W-1:0] sum;

  function automatic logic [ACC_W-1:0] accumulate(
    input logic [ACC_W-1:0] acc, input logic signed [COMB_W-1:0] v);
    return acc + {{(ACC_W-COMB_W){v[COMB_W-1]}}, v};
  endfunction

  assign sum    = accumulate({hi_in, lo_in}, comb);
  assign lo_out = sum[DATA_W-1:0];
  assign hi_out = sum[ACC_W-1:DATA_W];
endmodule

// File: rtl/dmac_long_unit.sv
module dmac_long_unit
  import dmac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int PROD_W = 2 * HALF_W,
  localparam int COMB_W = PROD_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [DATA_W-1:0]    rn_val,
  input  logic [DATA_W-1:0]    rm_val,
  input  logic [DATA_W-1:0]    acc_lo,
  input  logic [DATA_W-1:0]    acc_hi,
  input  logic                 cond_ok,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_lo,
  output logic [DATA_W-1:0]    out_hi,
  output logic [IDX_W-1:0]     out_lo_idx,
  output logic [IDX_W-1:0]     out_hi_idx,
  output logic                 out_wen
);
  dmac_ctrl_t               ctrl;
  logic                     will_write;
  logic signed [PROD_W-1:0] prod_lo, prod_hi;
  logic signed [COMB_W-1:0] comb;
  logic [DATA_W-1:0]        new_lo, new_hi;

  dmac_decode u_decode (
    .instr(instr), .cond_ok(cond_ok), .ctrl(ctrl), .will_write(will_write)
  );

  dmac_lanes #(.HALF_W(HALF_W)) u_lanes (
    .rn(rn_val), .rm(rm_val), .swap(ctrl.swap), .sub(ctrl.sub),
    .prod_lo(prod_lo), .prod_hi(prod_hi), .comb(comb)
  );

  dmac_accum #(.DATA_W(DATA_W), .COMB_W(COMB_W)) u_accum (
    .comb(comb), .lo_in(acc_lo), .hi_in(acc_hi),
    .lo_out(new_lo), .hi_out(new_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_wen   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_wen   <= in_valid & will_write;
    end
  end

  // Data path carries no reset; it is qualified by out_valid.
  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_lo     <= will_write ? new_lo : acc_lo;
      out_hi     <= will_write ? new_hi : acc_hi;
      out_lo_idx <= ctrl.lo_idx;
      out_hi_idx <= ctrl.hi_idx;
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_wen_qualified_r8: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> out_valid);
  p_always_code_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[COND_LSB +: COND_W] == COND_ALWAYS) |=> out_wen);
  p_hold_acc_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[COND_LSB +: COND_W] != COND_ALWAYS && !cond_ok)
    |=> (!out_wen && out_lo == $past(acc_lo) && out_hi == $past(acc_hi)));
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ctrl.sub && !prod_lo[PROD_W-1] && !prod_hi[PROD_W-1])
    |-> !comb[COMB_W-1]);
  p_lo_idx_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_lo_idx == $past(instr[LO_LSB +: IDX_W]));
endmodule

// File: tb/test_dmac_long_unit.sv
module test_dmac_long_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, rn_val = '0, rm_val = '0, acc_lo = '0, acc_hi = '0;
  logic        cond_ok = 1'b0;
  logic        out_valid, out_wen;
  logic [31:0] out_lo, out_hi;
  logic [3:0]  out_lo_idx, out_hi_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          issue;
    logic [31:0] lo, hi;
    logic [3:0]  li, hix;
    logic        wen;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  dmac_long_unit i_dmac_long_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .rn_val(rn_val), .rm_val(rm_val), .acc_lo(acc_lo), .acc_hi(acc_hi),
    .cond_ok(cond_ok), .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi),
    .out_lo_idx(out_lo_idx), .out_hi_idx(out_hi_idx), .out_wen(out_wen)
  );

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] hi_i,
      input logic [3:0] lo_i, input logic sub, input logic swp);
    return {c, 8'h74, hi_i, lo_i, 4'h3, 1'b0, sub, swp, 1'b1, 4'h2};
  endfunction

  // Reference: signed 64-bit integer arithmetic on the lane values.
  function automatic longint refcalc(input logic [31:0] rn, input logic [31:0] rm,
      input logic [31:0] lo, input logic [31:0] hi, input logic sub, input logic swp);
    longint a0, a1, b0, b1, acc;
    logic [31:0] r;
    r   = swp ? {rm[15:0], rm[31:16]} : rm;
    a0  = longint'(shortint'(rn[15:0]));
    a1  = longint'(shortint'(rn[31:16]));
    b0  = longint'(shortint'(r[15:0]));
    b1  = longint'(shortint'(r[31:16]));
    acc = longint'({hi, lo});
    return sub ? acc + a0 * b0 - a1 * b1 : acc + a0 * b0 + a1 * b1;
  endfunction

  task automatic drive(input logic [3:0] c, input logic [3:0] hi_i, input logic [3:0] lo_i,
      input logic sub, input logic swp, input logic [31:0] rn, input logic [31:0] rm,
      input logic [31:0] lo, input logic [31:0] hi, input logic ok, input string tag);
    exp_t e;
    logic [63:0] res;
    @(negedge clk);
    in_valid = 1'b1;
    instr = mk(c, hi_i, lo_i, sub, swp);
    rn_val = rn; rm_val = rm; acc_lo = lo; acc_hi = hi; cond_ok = ok;
    res = 64'(refcalc(rn, rm, lo, hi, sub, swp));
    e.issue = cyc; e.li = lo_i; e.hix = hi_i; e.tag = tag;
    e.wen = (c == 4'hE) || ok;
    e.lo = e.wen ? res[31:0] : lo;
    e.hi = e.wen ? res[63:32] : hi;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
      input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // Monitor: runs at each falling edge, before the driver of that edge is relevant.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (sb.size() > 0 && sb[0].issue == cyc - 1) begin
          exp_t e;
          e = sb.pop_front();
          chk(out_valid == 1'b1, {"R2 valid ", e.tag}, 64'(out_valid), 64'd1);
          chk(out_wen == e.wen, {"R8 wen ", e.tag}, 64'(out_wen), 64'(e.wen));
          chk(out_lo_idx == e.li && out_hi_idx == e.hix, {"R3 idx ", e.tag},
              {out_hi_idx, out_lo_idx}, {e.hix, e.li});
          chk({out_hi, out_lo} == {e.hi, e.lo}, {"R4-R9 data ", e.tag},
              {out_hi, out_lo}, {e.hi, e.lo});
        end else if (out_valid) begin
          chk(1'b0, "R2 spurious out_valid", 64'(out_valid), 64'd0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_wen == 0, "R1 during reset", {out_valid, out_wen}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 0 && out_wen == 0, "R1 after reset", {out_valid, out_wen}, 0);

    // R5/R6: all-ones halfwords, signed -1 * -1 = 1 per lane
    drive(4'hE, 4'd1, 4'd0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0, 32'd0, 1'b0, "all-ones add");
    // R6: 0x8000 both lanes, +2^31 total
    drive(4'hE, 4'd3, 4'd2, 1'b0, 1'b0, 32'h80008000, 32'h80008000, 32'd0, 32'd0, 1'b0, "R6 min-min add");
    drive(4'hE, 4'd3, 4'd2, 1'b1, 1'b0, 32'h80008000, 32'h80008000, 32'd5, 32'd0, 1'b0, "R6 min-min sub");
    // R4: swap off vs on with asymmetric lanes
    drive(4'hE, 4'd5, 4'd4, 1'b0, 1'b0, 32'h00030002, 32'h00070005, 32'd0, 32'd0, 1'b0, "R4 no swap");
    drive(4'hE, 4'd5, 4'd4, 1'b0, 1'b1, 32'h00030002, 32'h00070005, 32'd0, 32'd0, 1'b0, "R4 swap");
    // R5: subtract with unequal products, negative result
    drive(4'hE, 4'd7, 4'd6, 1'b1, 1'b0, 32'h00640001, 32'h00640001, 32'd0, 32'd0, 1'b0, "R5 sub negative");
    // R7: carry across boundary and wrap modulo 2^64
    drive(4'hE, 4'd9, 4'd8, 1'b0, 1'b0, 32'h00000001, 32'h00000002, 32'hFFFFFFFF, 32'h00000010, 1'b0, "R7 carry");
    drive(4'hE, 4'd9, 4'd8, 1'b0, 1'b0, 32'h00000001, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R7 wrap");
    drive(4'hE, 4'd9, 4'd8, 1'b1, 1'b0, 32'h00010000, 32'h00010000, 32'd0, 32'd0, 1'b0, "R7 borrow");
    // R8/R9: failed condition, then passed non-always code
    drive(4'h0, 4'd11, 4'd10, 1'b0, 1'b0, 32'h12345678, 32'h9ABCDEF0, 32'hCAFE0001, 32'h0000BEEF, 1'b0, "R9 cond fail");
    drive(4'h1, 4'd11, 4'd10, 1'b0, 1'b1, 32'h12345678, 32'h9ABCDEF0, 32'hCAFE0001, 32'h0000BEEF, 1'b1, "R8 cond pass");
    idle(3);

    for (int k = 0; k < 60; k++) begin
      logic [3:0] c;
      c = ($urandom_range(0, 2) == 0) ? 4'hE : 4'($urandom);
      drive(c, 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
            $urandom, $urandom, $urandom, $urandom, 1'($urandom), "random");
      if (k % 7 == 3) idle(2);
    end
    idle(4);
    chk(sb.size() == 0, "R2 all results delivered", 64'(sb.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule